// File: doc/BRIEF.md
# ModR/M and SIB address decoder

This block sits behind an x86-style opcode decoder and turns the addressing bytes that follow an opcode into an operand description. It accepts a byte stream one byte per handshake: first the ModR/M byte, then, when the form calls for one, a SIB byte, then a displacement of zero, one, two or four bytes, least significant byte first. From these bytes and from general-register values it reads through two combinational register-file read ports, it produces the reg field, a flag telling a register operand from a memory operand, the r/m register number, the effective address, the segment to use and the number of bytes it consumed.

Both 16-bit and 32-bit address sizes are handled. The size is chosen per operand by an input. The decoder covers the full 16-bit base/index table and the 32-bit forms, including the SIB form, the scaled index and the forms that have no base register. When no segment-override prefix is active, frame-pointer forms select the stack segment and all other forms select the data segment. An active override is passed through unchanged. The results are registered and announced by a one-cycle done pulse. The decoder takes the next ModR/M byte in that same cycle, so operand descriptions can stream back to back.

Top module: `modrm_addr_decoder`

## Requirements
- R1: A byte is taken on a rising edge where byte_valid and byte_ready are both high. byte_ready is low only during the single cycle that follows the edge taking the last byte of an operand description, and it is high at reset.
- R2: done goes high for exactly one cycle, one clock after the byte_ready-low cycle. All op_* outputs change only together with done and hold their values in between. After reset done is low, op_ea is 0 and op_len is 0.
- R3: The fields of the ModR/M byte are mod = bits 7:6, reg = bits 5:3 and r/m = bits 2:0. op_reg carries reg and op_rm carries r/m. When mod = 3, op_is_mem is 0, op_ea is 0, op_len is 1 and no further byte is taken. In every other case op_is_mem is 1.
- R4: Register numbers are 0 EAX, 1 ECX, 2 EDX, 3 EBX, 4 ESP, 5 EBP, 6 ESI, 7 EDI. In 32-bit mode with r/m other than 4, the address is the r/m register plus the displacement. mod 1 adds a sign-extended 8-bit displacement and mod 2 adds a 32-bit displacement. With mod 0 and r/m 5, the address is a 32-bit displacement alone. With mod 1 or 2 and r/m 5, the base is EBP.
- R5: In 32-bit mode, r/m 4 means a SIB byte follows the ModR/M byte. The index is SIB bits 5:3 and is shifted left by SIB bits 7:6. An index of 4 contributes zero. The base register is SIB bits 2:0.
- R6: In the SIB form with mod 0 and a base field of 5, there is no base register and a 32-bit displacement follows the SIB byte.
- R7: In 16-bit mode, r/m 0 to 7 select BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX. With mod 0, r/m 6 instead means a bare 16-bit displacement. mod 1 adds a sign-extended 8-bit displacement and mod 2 adds a 16-bit displacement.
- R8: In 16-bit mode only the low 16 bits of each register are used, and op_ea is the sum taken modulo 2^16, with bits 31:16 zero.
- R9: Segment codes are 0 ES, 1 CS, 2 SS, 3 DS. With no override active, op_seg is SS for 16-bit r/m 2 and 3, for 16-bit r/m 6 with mod 1 or 2, and for 32-bit r/m 5 with mod 1 or 2. In all other cases it is DS, including mod 3.
- R10: When ovr_en is high with the ModR/M byte, op_seg equals the ovr_sel value given with that byte, whatever the form.
- R11: op_len equals 1 + (1 when a SIB byte was taken) + the number of displacement bytes.
- R12: addr32, ovr_en and ovr_sel are sampled only with the ModR/M byte. Their values during the SIB and displacement bytes have no effect. Register values are read during the byte_ready-low cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | An addressing byte is offered |
| byte_data | input | 8 | Addressing byte |
| byte_ready | output | 1 | Decoder can take a byte |
| addr32 | input | 1 | 1 selects 32-bit address size, 0 selects 16-bit; sampled with the ModR/M byte |
| ovr_en | input | 1 | A segment-override prefix is active; sampled with the ModR/M byte |
| ovr_sel | input | 2 | Override segment code; sampled with the ModR/M byte |
| rf_a_idx | output | 3 | Base register number for read port A |
| rf_a_data | input | 32 | Register value for rf_a_idx, combinational |
| rf_b_idx | output | 3 | Index register number for read port B |
| rf_b_data | input | 32 | Register value for rf_b_idx, combinational |
| done | output | 1 | One-cycle pulse: a new operand description is on op_* |
| op_reg | output | 3 | reg field |
| op_is_mem | output | 1 | 1 for a memory operand, 0 for a register operand |
| op_rm | output | 3 | r/m field, the second register number when op_is_mem is 0 |
| op_ea | output | 32 | Effective address |
| op_seg | output | 2 | Selected segment code |
| op_len | output | 3 | Number of addressing bytes consumed |

## Verification
The done pulse of one operand description and the acceptance of the next ModR/M byte fall in the same cycle when bytes are offered without gaps. A single-byte register form can even complete in that cycle. Back-to-back streams, with many single-byte register forms among them, provoke this case. A behavioural model in the bench predicts byte_ready and done every cycle, and the results at each done must match the model while the next description is already being taken. Other runs insert random idle cycles and flip addr32 and the override inputs during SIB and displacement bytes, to show that only the values given with the ModR/M byte count.

// File: rtl/modrm_dec_pkg.sv
package modrm_dec_pkg;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_e;

  localparam logic [2:0] RN_BX = 3'd3;
  localparam logic [2:0] RN_SP = 3'd4;
  localparam logic [2:0] RN_BP = 3'd5;
  localparam logic [2:0] RN_SI = 3'd6;
  localparam logic [2:0] RN_DI = 3'd7;

  typedef enum logic [1:0] {
    ST_MODRM = 2'd0,
    ST_SIB   = 2'd1,
    ST_DISP  = 2'd2,
    ST_CALC  = 2'd3
  } col_state_e;

  // Number of displacement bytes for a form; sib_base only matters for the SIB form.
  function automatic logic [2:0] disp_len(input logic a32, input logic [1:0] md,
                                          input logic [2:0] rm, input logic [2:0] sib_base);
    logic [2:0] n;
    n = 3'd0;
    case (md)
      2'd1: n = 3'd1;
      2'd2: n = a32 ? 3'd4 : 3'd2;
      2'd0: begin
        if (a32 && rm == RN_BP) n = 3'd4;
        else if (a32 && rm == RN_SP && sib_base == RN_BP) n = 3'd4;
        else if (!a32 && rm == RN_SI) n = 3'd2;
      end
      default: n = 3'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/modrm_byte_collect.sv
module modrm_byte_collect
  import modrm_dec_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             addr32,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_sel,
  output logic             byte_ready,
  output logic             calc,
  output logic [1:0]       f_mod,
  output logic [2:0]       f_reg,
  output logic [2:0]       f_rm,
  output logic [7:0]       f_sib,
  output logic             has_sib,
  output logic [REG_W-1:0] disp,
  output logic [2:0]       dlen,
  output logic             a32_q,
  output logic             ovr_en_q,
  output logic [1:0]       ovr_sel_q
);

  col_state_e st;
  logic [2:0] didx;
  logic [2:0] len_now;
  logic       want_sib;

  // Displacement length known at the byte being taken now.
  always_comb begin
    if (st == ST_SIB) len_now = disp_len(1'b1, f_mod, RN_SP, byte_data[2:0]);
    else              len_now = disp_len(addr32, byte_data[7:6], byte_data[2:0], 3'd0);
    want_sib = addr32 && (byte_data[2:0] == RN_SP) && (byte_data[7:6] != 2'd3);
  end

  assign byte_ready = (st != ST_CALC);
  assign calc       = (st == ST_CALC);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_MODRM;
      f_mod     <= '0;
      f_reg     <= '0;
      f_rm      <= '0;
      f_sib     <= '0;
      has_sib   <= 1'b0;
      disp      <= '0;
      dlen      <= '0;
      didx      <= '0;
      a32_q     <= 1'b0;
      ovr_en_q  <= 1'b0;
      ovr_sel_q <= '0;
    end else begin
      case (st)
        ST_MODRM: if (byte_valid) begin
          f_mod     <= byte_data[7:6];
          f_reg     <= byte_data[5:3];
          f_rm      <= byte_data[2:0];
          f_sib     <= '0;
          has_sib   <= 1'b0;
          disp      <= '0;
          didx      <= '0;
          a32_q     <= addr32;
          ovr_en_q  <= ovr_en;
          ovr_sel_q <= ovr_sel;
          if (want_sib) begin
            dlen <= '0;
            st   <= ST_SIB;
          end else begin
            dlen <= len_now;
            st   <= (len_now == 3'd0) ? ST_CALC : ST_DISP;
          end
        end
        ST_SIB: if (byte_valid) begin
          f_sib   <= byte_data;
          has_sib <= 1'b1;
          dlen    <= len_now;
          st      <= (len_now == 3'd0) ? ST_CALC : ST_DISP;
        end
        ST_DISP: if (byte_valid) begin
          disp[didx*8 +: 8] <= byte_data;
          didx              <= didx + 3'd1;
          if (didx + 3'd1 == dlen) st <= ST_CALC;
        end
        default: st <= ST_MODRM;
      endcase
    end
  end

  // R11: the displacement counter never runs past the length chosen for the form.
  p_disp_index_r11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DISP) |-> (didx < dlen));

  // R1: the byte_ready-low cycle lasts a single cycle.
  p_calc_single_r1: assert property (@(posedge clk) disable iff (rst)
    calc |=> !calc);

endmodule

// File: rtl/modrm_ea_calc.sv
module modrm_ea_calc
  import modrm_dec_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic [1:0]       f_mod,
  input  logic [2:0]       f_rm,
  input  logic [7:0]       f_sib,
  input  logic             has_sib,
  input  logic [REG_W-1:0] disp,
  input  logic [2:0]       dlen,
  input  logic             a32_q,
  input  logic             ovr_en_q,
  input  logic [1:0]       ovr_sel_q,
  output logic [2:0]       rf_a_idx,
  input  logic [REG_W-1:0] rf_a_data,
  output logic [2:0]       rf_b_idx,
  input  logic [REG_W-1:0] rf_b_data,
  output logic [REG_W-1:0] ea,
  output logic [1:0]       seg,
  output logic [2:0]       nbytes
);

  logic             use_a, use_b, bp_form;
  logic [1:0]       sh;
  logic [REG_W-1:0] dx, a_term, b_term, sum;

  always_comb begin
    rf_a_idx = f_rm;
    rf_b_idx = RN_SI;
    use_a    = 1'b1;
    use_b    = 1'b0;
    sh       = 2'd0;
    bp_form  = 1'b0;
    if (a32_q) begin
      if (f_rm == RN_SP) begin
        rf_a_idx = f_sib[2:0];
        use_a    = !((f_mod == 2'd0) && (f_sib[2:0] == RN_BP));
        rf_b_idx = f_sib[5:3];
        use_b    = (f_sib[5:3] != RN_SP);
        sh       = f_sib[7:6];
      end else if (f_rm == RN_BP) begin
        use_a    = (f_mod != 2'd0);
        bp_form  = (f_mod != 2'd0);
      end
    end else begin
      case (f_rm)
        3'd0: begin rf_a_idx = RN_BX; rf_b_idx = RN_SI; use_b = 1'b1; end
        3'd1: begin rf_a_idx = RN_BX; rf_b_idx = RN_DI; use_b = 1'b1; end
        3'd2: begin rf_a_idx = RN_BP; rf_b_idx = RN_SI; use_b = 1'b1; bp_form = 1'b1; end
        3'd3: begin rf_a_idx = RN_BP; rf_b_idx = RN_DI; use_b = 1'b1; bp_form = 1'b1; end
        3'd4: rf_a_idx = RN_SI;
        3'd5: rf_a_idx = RN_DI;
        3'd6: begin
          rf_a_idx = RN_BP;
          use_a    = (f_mod != 2'd0);
          bp_form  = (f_mod != 2'd0);
        end
        default: rf_a_idx = RN_BX;
      endcase
    end

    case (dlen)
      3'd1:    dx = {{(REG_W-8){disp[7]}}, disp[7:0]};
      3'd2:    dx = {{(REG_W-16){disp[15]}}, disp[15:0]};
      default: dx = disp;
    endcase

    a_term = use_a ? rf_a_data : '0;
    b_term = use_b ? (rf_b_data << sh) : '0;
    sum    = a_term + b_term + dx;

    if (f_mod == 2'd3)  ea = '0;
    else if (a32_q)     ea = sum;
    else                ea = {{(REG_W-16){1'b0}}, sum[15:0]};

    if (ovr_en_q)                          seg = ovr_sel_q;
    else if (bp_form && f_mod != 2'd3)     seg = SEG_SS;
    else                                   seg = SEG_DS;

    nbytes = 3'd1 + {2'b00, has_sib} + dlen;
  end

endmodule

// File: rtl/modrm_addr_decoder.sv
module modrm_addr_decoder
  import modrm_dec_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  output logic             byte_ready,
  input  logic             addr32,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_sel,
  output logic [2:0]       rf_a_idx,
  input  logic [REG_W-1:0] rf_a_data,
  output logic [2:0]       rf_b_idx,
  input  logic [REG_W-1:0] rf_b_data,
  output logic             done,
  output logic [2:0]       op_reg,
  output logic             op_is_mem,
  output logic [2:0]       op_rm,
  output logic [REG_W-1:0] op_ea,
  output logic [1:0]       op_seg,
  output logic [2:0]       op_len
);

  logic             calc, has_sib, a32_q, ovr_en_q;
  logic [1:0]       f_mod, ovr_sel_q, seg_c;
  logic [2:0]       f_reg, f_rm, dlen, nbytes_c;
  logic [7:0]       f_sib;
  logic [REG_W-1:0] disp, ea_c;

  modrm_byte_collect #(.REG_W(REG_W)) u_collect (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .addr32(addr32), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .byte_ready(byte_ready), .calc(calc),
    .f_mod(f_mod), .f_reg(f_reg), .f_rm(f_rm), .f_sib(f_sib), .has_sib(has_sib),
    .disp(disp), .dlen(dlen), .a32_q(a32_q), .ovr_en_q(ovr_en_q), .ovr_sel_q(ovr_sel_q)
  );

  modrm_ea_calc #(.REG_W(REG_W)) u_calc (
    .f_mod(f_mod), .f_rm(f_rm), .f_sib(f_sib), .has_sib(has_sib),
    .disp(disp), .dlen(dlen), .a32_q(a32_q), .ovr_en_q(ovr_en_q), .ovr_sel_q(ovr_sel_q),
    .rf_a_idx(rf_a_idx), .rf_a_data(rf_a_data), .rf_b_idx(rf_b_idx), .rf_b_data(rf_b_data),
    .ea(ea_c), .seg(seg_c), .nbytes(nbytes_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      op_reg    <= '0;
      op_is_mem <= 1'b0;
      op_rm     <= '0;
      op_ea     <= '0;
      op_seg    <= SEG_DS;
      op_len    <= '0;
    end else begin
      done <= calc;
      if (calc) begin
        op_reg    <= f_reg;
        op_is_mem <= (f_mod != 2'd3);
        op_rm     <= f_rm;
        op_ea     <= ea_c;
        op_seg    <= seg_c;
        op_len    <= nbytes_c;
      end
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_ready_at_done_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> byte_ready);

  p_outputs_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !done |=> (done || ($stable(op_ea) && $stable(op_len) && $stable(op_seg))));

  p_regform_r3: assert property (@(posedge clk) disable iff (rst)
    (done && !op_is_mem) |-> (op_len == 3'd1 && op_ea == '0));

  p_ea16_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (done && op_is_mem && !a32_q) |-> (op_ea[REG_W-1:16] == '0));

  p_override_r10: assert property (@(posedge clk) disable iff (rst)
    (done && ovr_en_q) |-> (op_seg == ovr_sel_q));

  p_len_bound_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> (op_len >= 3'd1 && op_len <= 3'd6));

endmodule

// File: tb/modrm_addr_decoder_test.sv
module modrm_addr_decoder_test;

  logic        clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, byte_valid, byte_ready, addr32, ovr_en, done, op_is_mem;
  logic [7:0]  byte_data;
  logic [1:0]  ovr_sel, op_seg;
  logic [2:0]  rf_a_idx, rf_b_idx, op_reg, op_rm, op_len;
  logic [31:0] rf_a_data, rf_b_data, op_ea;
  logic [31:0] rf [8];

  assign rf_a_data = rf[rf_a_idx];
  assign rf_b_data = rf[rf_b_idx];

  modrm_addr_decoder uut (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .addr32(addr32), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .rf_a_idx(rf_a_idx), .rf_a_data(rf_a_data), .rf_b_idx(rf_b_idx), .rf_b_data(rf_b_data),
    .done(done), .op_reg(op_reg), .op_is_mem(op_is_mem), .op_rm(op_rm),
    .op_ea(op_ea), .op_seg(op_seg), .op_len(op_len)
  );

  typedef struct {
    logic [47:0] b;
    bit          a32;
    bit          oen;
    logic [1:0]  osel;
  } instr_t;

  typedef struct {
    int          len;
    logic [2:0]  rg;
    bit          mem;
    logic [2:0]  rm;
    logic [31:0] ea;
    logic [1:0]  seg;
    string       tag;
    string       stag;
  } exp_t;

  exp_t        eq[$];
  int          checks = 0, fails = 0;
  logic [31:0] seed = 32'h1234_5678;
  bit          chk_on = 0;
  bit          exp_ready = 1, exp_done = 0, pend = 0;
  int          ci = 0, di = 0, bc = 0;

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // Behavioural expectation from the requirements.
  function automatic exp_t model(instr_t t);
    exp_t e;
    logic [7:0]  m, s;
    int          md, rm, pos, dn;
    logic [31:0] basev, idxv, dv;
    bit          bp;
    m = t.b[7:0]; md = m[7:6]; rm = m[2:0];
    e.rg = m[5:3]; e.rm = m[2:0];
    pos = 1; dn = 0; basev = 0; idxv = 0; dv = 0; bp = 0;
    if (md == 3) begin
      e.mem = 0; e.tag = "R3";
    end else begin
      e.mem = 1;
      if (t.a32) begin
        e.tag = "R4 R12";
        if (rm == 4) begin
          s = t.b[15:8]; pos = 2; e.tag = "R5 R12";
          if (s[5:3] != 3'd4) idxv = rf[s[5:3]] << s[7:6];
          if (md == 0 && s[2:0] == 3'd5) begin dn = 4; e.tag = "R6 R12"; end
          else basev = rf[s[2:0]];
        end else if (rm == 5 && md == 0) dn = 4;
        else begin basev = rf[rm]; bp = (rm == 5); end
        if (md == 1) dn = 1;
        if (md == 2) dn = 4;
      end else begin
        e.tag = "R7 R8 R12";
        case (rm)
          0: basev = rf[3][15:0] + rf[6][15:0];
          1: basev = rf[3][15:0] + rf[7][15:0];
          2: basev = rf[5][15:0] + rf[6][15:0];
          3: basev = rf[5][15:0] + rf[7][15:0];
          4: basev = rf[6][15:0];
          5: basev = rf[7][15:0];
          6: basev = (md == 0) ? 0 : rf[5][15:0];
          default: basev = rf[3][15:0];
        endcase
        bp = (rm == 2) || (rm == 3) || (rm == 6 && md != 0);
        if (md == 1) dn = 1;
        if (md == 2) dn = 2;
        if (md == 0 && rm == 6) dn = 2;
      end
      for (int k = 0; k < dn; k++) dv[8*k +: 8] = t.b[8*(pos+k) +: 8];
      if (dn == 1) dv = {{24{dv[7]}}, dv[7:0]};
      if (dn == 2) dv = {{16{dv[15]}}, dv[15:0]};
    end
    e.ea  = (md == 3) ? 32'd0 : basev + idxv + dv;
    if (!t.a32) e.ea = e.ea & 32'h0000_FFFF;
    e.len = pos + dn;
    if (t.oen) begin e.seg = t.osel; e.stag = "R10"; end
    else begin e.seg = bp ? 2'd2 : 2'd3; e.stag = "R9"; end
    return e;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  // Cycle-by-cycle reference of handshake and done, plus field checks at each done.
  always @(negedge clk) begin
    if (chk_on) begin
      bit nr, nd;
      chk(byte_ready === exp_ready, "R1 byte_ready", {31'd0, byte_ready}, {31'd0, exp_ready});
      chk(done === exp_done, "R2 done", {31'd0, done}, {31'd0, exp_done});
      if (exp_done && di < eq.size()) begin
        exp_t e;
        e = eq[di];
        di++;
        chk(op_reg === e.rg, "R3 op_reg", {29'd0, op_reg}, {29'd0, e.rg});
        chk(op_rm === e.rm, "R3 op_rm", {29'd0, op_rm}, {29'd0, e.rm});
        chk(op_is_mem === e.mem, "R3 op_is_mem", {31'd0, op_is_mem}, {31'd0, e.mem});
        chk(op_ea === e.ea, {e.tag, " op_ea"}, op_ea, e.ea);
        chk(op_seg === e.seg, {e.stag, " op_seg"}, {30'd0, op_seg}, {30'd0, e.seg});
        chk(op_len === e.len[2:0], "R11 op_len", {29'd0, op_len}, e.len);
      end
      nd = pend;
      nr = 1;
      if (pend) pend = 0;
      else if (exp_ready && byte_valid && ci < eq.size()) begin
        bc++;
        if (bc == eq[ci].len) begin
          ci++; bc = 0; pend = 1; nr = 0;
        end
      end
      exp_ready = nr;
      exp_done  = nd;
    end
  end

  // R12: after the ModR/M byte the size and override inputs are driven inverted.
  task automatic send(instr_t t, bit gaps);
    exp_t e;
    bit   ok;
    e = model(t);
    eq.push_back(e);
    for (int j = 0; j < e.len; j++) begin
      byte_valid = 0;
      if (gaps) begin
        int n;
        n = int'(rnd() % 3);
        for (int g = 0; g < n; g++) begin @(posedge clk); #1; end
      end
      byte_valid = 1;
      byte_data  = t.b[8*j +: 8];
      addr32     = (j == 0) ? t.a32  : ~t.a32;
      ovr_en     = (j == 0) ? t.oen  : ~t.oen;
      ovr_sel    = (j == 0) ? t.osel : ~t.osel;
      do begin
        @(negedge clk); ok = byte_ready;
        @(posedge clk); #1;
      end while (!ok);
    end
    byte_valid = 0;
  endtask

  function automatic instr_t mk(logic [47:0] b, bit a32, bit oen, logic [1:0] osel);
    instr_t t;
    t.b = b; t.a32 = a32; t.oen = oen; t.osel = osel;
    return t;
  endfunction

  task automatic sweep(bit gaps);
    for (int a = 0; a < 2; a++)
      for (int md = 0; md < 4; md++)
        for (int rm = 0; rm < 8; rm++) begin
          logic [31:0] r1, r2, r3;
          logic [7:0]  mrm;
          r1 = rnd(); r2 = rnd(); r3 = rnd();
          mrm = {md[1:0], r3[2:0], rm[2:0]};
          send(mk({r1, r2[7:0], mrm}, a[0], (r3[9:8] == 2'd0), r3[11:10]), gaps);
        end
  endtask

  initial begin
    rf[0] = 32'h0000_1000; rf[1] = 32'h8000_0004; rf[2] = 32'hDEAD_BEEF;
    rf[3] = 32'h1234_FFF0; rf[4] = 32'h0000_7FFC; rf[5] = 32'hFFFF_FF00;
    rf[6] = 32'h5555_0020; rf[7] = 32'hAAAA_8001;
    rst = 1; byte_valid = 0; byte_data = 0; addr32 = 0; ovr_en = 0; ovr_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done === 1'b0, "R2 reset done", {31'd0, done}, 0);
    chk(op_ea === 32'd0, "R2 reset op_ea", op_ea, 0);
    chk(op_len === 3'd0, "R2 reset op_len", {29'd0, op_len}, 0);
    chk(byte_ready === 1'b1, "R1 reset ready", {31'd0, byte_ready}, 1);
    @(posedge clk); #1;
    rst = 0; chk_on = 1;
    send(mk(48'h0000_0000_00D8, 1, 0, 0), 0);
    send(mk(48'h0000_0000_0000, 1, 0, 0), 0);
    send(mk(48'h0012_3456_7805, 1, 0, 0), 0);
    send(mk(48'h0000_0000_FF45, 1, 0, 0), 0);
    send(mk(48'h0080_0000_1081, 1, 0, 0), 0);
    send(mk(48'h0000_0000_8804, 1, 0, 0), 0);
    send(mk(48'h0000_0000_6304, 1, 0, 0), 0);
    send(mk(48'h0000_0100_C504, 1, 0, 0), 0);
    send(mk(48'h0000_00F0_0544, 1, 0, 0), 0);
    send(mk(48'h0000_0000_0000, 0, 0, 0), 0);
    send(mk(48'h0000_0080_0006, 0, 0, 0), 0);
    send(mk(48'h0000_0000_8046, 0, 0, 0), 0);
    send(mk(48'h0000_00FF_FF92, 0, 0, 0), 0);
    send(mk(48'h0000_0000_0045, 1, 1, 2'd0), 0);
    send(mk(48'h0000_0000_0003, 0, 1, 2'd1), 0);
    send(mk(48'h0000_0000_00C7, 0, 0, 0), 0);
    sweep(1);
    sweep(0);
    repeat (6) @(posedge clk);
    #1;
    chk(di == eq.size(), "R2 done count", di, eq.size());
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog act=%0d exp=%0d", di, eq.size());
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule